// File: doc/BRIEF.md
# Memory BIST Pattern Run Controller

This block drives a self-test run over a memory data path. A 3-bit instruction, given with a valid strobe, starts, halts or clears a run. The pattern, run length, failure threshold, loopback or DRAM mode and lane enables are sampled when a run starts. While a run is active, the block issues one test word per cycle. The word is a walking zero, a walking one, a 16-bit LFSR sequence or a fixed user word. Each issued word is also pushed into an internal expected-word FIFO.

Words come back on the return port, tagged by a valid strobe. They arrive in issue order after a fixed latency. Each returned word is compared against the head of the FIFO. Mismatches are counted in a saturating failure counter and raise a sticky fail flag.

A run ends in one of three ways:
- A bounded run has issued its programmed number of words and every return has been compared.
- Stop-on-failure is set and the threshold-plus-one failure arrives.
- A halt instruction arrives.

An unbounded run ends only on a halt or on the first failure. Busy and done report where the sequence stands.

Top module: `mbist_runner`

## Requirements
- R1: After reset, busy, done, fail, fail_cnt, word_cnt and issue_valid are all zero.
- R2: Instruction codes are 0 no-op, 1 start, 2 halt, 3 clear; codes 4 to 7 have no effect, and a start while busy has no effect (the run and its word count continue).
- R3: A start while both ac_en and dx_en are high is rejected: busy stays low.
- R4: Pattern select 1 issues a walking one and 0 a walking zero; word k of a run has its single differing bit at position k mod DW, starting at bit 0.
- R5: Pattern select 2 issues a 16-bit LFSR, reseeded to 16'hACE1 on every start. Each next value is {l[14:0], l[15]^l[13]^l[12]^l[10]}, and data bit i carries LFSR bit i mod 16.
- R6: Pattern select 3 issues the user word sampled at start on every cycle.
- R7: With inf_run low, exactly word_total words are issued (none for zero). done rises once the last return has been compared, and word_cnt then equals word_total.
- R8: Each returned word that differs from its expected word adds one to fail_cnt and sets fail. fail stays set across later runs and is cleared only by the clear instruction. A start resets fail_cnt to zero.
- R9: With stop_nf high, the run ends once fail_cnt would pass nf_thr, that is on failure nf_thr+1. Issue stops and fail_cnt reads nf_thr+1 (255 when nf_thr is 255).
- R10: With inf_run high and stop_nf low, issuing continues until a halt or the first failure, which ends the run with fail_cnt at 1.
- R11: A halt ends an active run at the next edge: busy falls, done rises and no further word is issued. done holds until the next start or clear.
- R12: The mask lanes are enabled only when dm_en is high and dram_mode is 0 (loopback). When enabled, issue_mask carries the low MW bits of the issued word and ret_mask is compared. Otherwise issue_mask is zero and ret_mask is ignored.
- R13: fail_cnt saturates at 255.
- R14: The clear instruction aborts any run and zeroes busy, done, fail, fail_cnt and word_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction strobe |
| cmd | input | 3 | Instruction code |
| pat_sel | input | 2 | Pattern select |
| inf_run | input | 1 | Unbounded run |
| stop_nf | input | 1 | Stop on failure threshold |
| nf_thr | input | 8 | Failure threshold |
| dram_mode | input | 1 | 0 loopback, 1 DRAM access |
| ac_en | input | 1 | Address/command lane test enable |
| dx_en | input | 1 | Data lane test enable |
| dm_en | input | 1 | Mask lane test enable |
| user_word | input | DW | User pattern word |
| word_total | input | CW | Words in a bounded run |
| issue_valid | output | 1 | Test word issued this cycle |
| issue_data | output | DW | Issued data word |
| issue_mask | output | MW | Issued mask lanes |
| ret_valid | input | 1 | Returned word strobe |
| ret_data | input | DW | Returned data word |
| ret_mask | input | MW | Returned mask lanes |
| busy | output | 1 | Run active |
| done | output | 1 | Run ended |
| fail | output | 1 | Sticky mismatch flag |
| fail_cnt | output | 8 | Mismatch count |
| word_cnt | output | CW | Words issued in this run |

## Verification
Some properties are checked by assertions on every cycle:
- A bounded run never counts past its total.
- busy and done are never high together.
- done holds until a start or clear.
- fail stays set until a clear.
- fail_cnt holds at 255 once saturated.
- With stop-on-failure set, fail_cnt never passes the threshold while the run is active.
- The FIFO occupancy stays within its depth.

The bench scenarios are needed for the rest:
- The exact pattern sequences and the mask-lane gating.
- Which returned words count as failures.
- The three ways a run can end.
- The rejection of conflicting lane enables and the handling of reserved codes.

// File: rtl/mbist_runner.sv
module mbist_runner #(
  parameter int DW = 16,
  parameter int FD = 8,
  parameter int CW = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int MW = (DW + 7) / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [1:0]    pat_sel,
  input  logic          inf_run,
  input  logic          stop_nf,
  input  logic [7:0]    nf_thr,
  input  logic          dram_mode,
  input  logic          ac_en,
  input  logic          dx_en,
  input  logic          dm_en,
  input  logic [DW-1:0] user_word,
  input  logic [CW-1:0] word_total,
  output logic          issue_valid,
  output logic [DW-1:0] issue_data,
  output logic [MW-1:0] issue_mask,
  input  logic          ret_valid,
  input  logic [DW-1:0] ret_data,
  input  logic [MW-1:0] ret_mask,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [7:0]    fail_cnt,
  output logic [CW-1:0] word_cnt
);
  localparam int IW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int AW  = (FD > 1) ? $clog2(FD) : 1;
  localparam int NW  = $clog2(FD + 1);
  localparam int PW  = DW + MW;

  logic [1:0]    pat_q;
  logic          inf_q, sonf_q, dm_q;
  logic [7:0]    thr_q;
  logic [CW-1:0] tot_q;
  logic [DW-1:0] user_q;
  logic [IW-1:0] idx_q;
  logic [15:0]   lfsr_q;
  logic [PW-1:0] mem [FD];
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q;

  logic cmd_start, cmd_halt, cmd_clr;
  assign cmd_start = cmd_valid && cmd == 3'd1 && !busy && !(ac_en && dx_en);
  assign cmd_halt  = cmd_valid && cmd == 3'd2 && busy;
  assign cmd_clr   = cmd_valid && cmd == 3'd3;

  logic [DW-1:0] walk, lfsr_rep, pat_w;
  assign walk = {{(DW-1){1'b0}}, 1'b1} << idx_q;

  always_comb begin
    for (int i = 0; i < DW; i++) lfsr_rep[i] = lfsr_q[i % 16];
  end

  always_comb begin
    case (pat_q)
      2'd0:    pat_w = ~walk;
      2'd1:    pat_w = walk;
      2'd2:    pat_w = lfsr_rep;
      default: pat_w = user_q;
    endcase
  end

  logic more, pop, mism, fail_end, drained, end_run;
  logic [PW-1:0] head;
  assign more        = inf_q || (word_cnt < tot_q);
  assign issue_valid = busy && more && (cnt_q != NW'(FD));
  assign issue_data  = pat_w;
  assign issue_mask  = dm_q ? pat_w[MW-1:0] : '0;

  assign head     = mem[rp_q];
  assign pop      = busy && ret_valid && (cnt_q != '0);
  assign mism     = pop && ((ret_data != head[DW-1:0]) ||
                            (dm_q && ret_mask != head[PW-1:DW]));
  assign fail_end = mism && (sonf_q ? (fail_cnt == thr_q) : inf_q);
  assign drained  = !more && (cnt_q == '0);
  assign end_run  = busy && (cmd_halt || fail_end || drained);

  always_ff @(posedge clk) begin
    if (issue_valid) mem[wp_q] <= {issue_mask, issue_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0;
      fail_cnt <= '0; word_cnt <= '0;
      pat_q <= '0; inf_q <= 1'b0; sonf_q <= 1'b0; dm_q <= 1'b0;
      thr_q <= '0; tot_q <= '0; user_q <= '0;
      idx_q <= '0; lfsr_q <= SEED;
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (cmd_clr) begin
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0;
      fail_cnt <= '0; word_cnt <= '0;
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (cmd_start) begin
      busy <= 1'b1; done <= 1'b0;
      fail_cnt <= '0; word_cnt <= '0;
      pat_q <= pat_sel; inf_q <= inf_run; sonf_q <= stop_nf;
      dm_q <= dm_en && !dram_mode;
      thr_q <= nf_thr; tot_q <= word_total; user_q <= user_word;
      idx_q <= '0; lfsr_q <= SEED;
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (issue_valid) begin
        word_cnt <= word_cnt + 1'b1;
        idx_q    <= (idx_q == IW'(DW - 1)) ? '0 : idx_q + 1'b1;
        lfsr_q   <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      end
      if (mism) begin
        fail     <= 1'b1;
        fail_cnt <= (fail_cnt == 8'hFF) ? 8'hFF : fail_cnt + 1'b1;
      end
      if (end_run) begin
        busy <= 1'b0; done <= 1'b1;
        wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
        if (issue_valid) wp_q <= (wp_q == AW'(FD - 1)) ? '0 : wp_q + 1'b1;
        if (pop)         rp_q <= (rp_q == AW'(FD - 1)) ? '0 : rp_q + 1'b1;
        case ({issue_valid, pop})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  // R7
  bounded_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !inf_q) |-> word_cnt <= tot_q);

  // R7
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(FD));

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_start && !cmd_clr) |=> done);

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !cmd_clr) |=> fail);

  // R13
  fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fail_cnt) == 8'hFF && !$past(cmd_clr) && !$past(cmd_start)) |-> fail_cnt == 8'hFF);

  // R9
  nth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sonf_q) |-> fail_cnt <= thr_q);
endmodule

// File: tb/tb_mbist_runner.sv
`timescale 1ns/1ps
module tb_mbist_runner;
  localparam int DW = 16;
  localparam int MW = 2;
  localparam int CW = 16;
  localparam int LAT = 3;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] pat_sel = '0;
  logic inf_run = 1'b0, stop_nf = 1'b0, dram_mode = 1'b0;
  logic ac_en = 1'b0, dx_en = 1'b1, dm_en = 1'b0;
  logic [7:0] nf_thr = '0;
  logic [DW-1:0] user_word = '0;
  logic [CW-1:0] word_total = '0;
  logic issue_valid, ret_valid;
  logic [DW-1:0] issue_data, ret_data;
  logic [MW-1:0] issue_mask, ret_mask;
  logic busy, done, fail;
  logic [7:0] fail_cnt;
  logic [CW-1:0] word_cnt;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  logic [DW-1:0] log_d [LOGN];
  logic [MW-1:0] log_m [LOGN];
  int c_lo = 0, c_hi = 0;
  logic [DW-1:0] flip_d = '0;
  logic [MW-1:0] flip_m = '0;
  logic          pv [LAT];
  logic [DW-1:0] pd [LAT];
  logic [MW-1:0] pm [LAT];

  always #5 clk = ~clk;

  mbist_runner #(.DW(DW), .FD(8), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .pat_sel(pat_sel), .inf_run(inf_run), .stop_nf(stop_nf), .nf_thr(nf_thr),
    .dram_mode(dram_mode), .ac_en(ac_en), .dx_en(dx_en), .dm_en(dm_en),
    .user_word(user_word), .word_total(word_total),
    .issue_valid(issue_valid), .issue_data(issue_data), .issue_mask(issue_mask),
    .ret_valid(ret_valid), .ret_data(ret_data), .ret_mask(ret_mask),
    .busy(busy), .done(done), .fail(fail), .fail_cnt(fail_cnt), .word_cnt(word_cnt));

  always @(negedge clk) begin
    if (issue_valid && log_n < LOGN) begin
      log_d[log_n] = issue_data;
      log_m[log_n] = issue_mask;
      log_n = log_n + 1;
    end
  end

  always @(posedge clk) begin
    logic bad;
    bad = (log_n >= c_lo) && (log_n < c_hi);
    pv[0] <= issue_valid;
    pd[0] <= issue_data ^ (bad ? flip_d : '0);
    pm[0] <= issue_mask ^ (bad ? flip_m : '0);
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; pm[i] <= pm[i-1];
    end
  end
  assign ret_valid = pv[LAT-1];
  assign ret_data  = pd[LAT-1];
  assign ret_mask  = pm[LAT-1];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] p, input logic inf, input logic sn, input logic [7:0] th,
                     input logic dram, input logic dm, input int tot);
    @(negedge clk);
    pat_sel = p; inf_run = inf; stop_nf = sn; nf_thr = th;
    dram_mode = dram; dm_en = dm; word_total = CW'(tot);
    ac_en = 1'b0; dx_en = 1'b1;
  endtask

  task automatic run(output int base, input int lo, input int hi,
                     input logic [DW-1:0] fd, input logic [MW-1:0] fm);
    @(posedge clk);
    base = log_n; c_lo = log_n + lo; c_hi = log_n + hi; flip_d = fd; flip_m = fm;
    send(3'd1);
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    check(done === 1'b1, req, done, 1);
  endtask

  task automatic t_reset;
    check(busy === 0 && done === 0 && fail === 0, "R1 flags", {busy, done, fail}, 0);
    check(fail_cnt === 0 && word_cnt === 0, "R1 counts", word_cnt, 0);
    check(issue_valid === 0, "R1 issue", issue_valid, 0);
  endtask

  task automatic t_walk(input logic one);
    int base, errs;
    cfg(one ? 2'd1 : 2'd0, 0, 0, 0, 0, 0, 20);
    run(base, 0, 0, '0, '0);
    wait_done("R7 walk done");
    errs = 0;
    for (int k = 0; k < 20; k++) begin
      logic [DW-1:0] e;
      e = DW'(1) << (k % DW);
      if (!one) e = ~e;
      if (log_d[base+k] !== e) errs++;
    end
    check(errs == 0, "R4 walking pattern", errs, 0);
    check(log_n - base == 20 && word_cnt == 20, "R7 word count", log_n - base, 20);
    check(fail_cnt == 0 && busy == 0, "R7 clean end", fail_cnt, 0);
  endtask

  task automatic t_lfsr;
    int base, errs;
    logic [15:0] l;
    cfg(2'd2, 0, 0, 0, 0, 0, 10);
    run(base, 0, 0, '0, '0);
    wait_done("R5 done");
    errs = 0; l = 16'hACE1;
    for (int k = 0; k < 10; k++) begin
      if (log_d[base+k] !== l) errs++;
      l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    end
    check(errs == 0, "R5 lfsr sequence", errs, 0);
  endtask

  task automatic t_user;
    int base, errs;
    @(negedge clk); user_word = 16'h5AC3;
    cfg(2'd3, 0, 0, 0, 0, 0, 4);
    run(base, 0, 0, '0, '0);
    @(negedge clk); user_word = 16'h0000;
    wait_done("R6 done");
    errs = 0;
    for (int k = 0; k < 4; k++) if (log_d[base+k] !== 16'h5AC3) errs++;
    check(errs == 0 && log_n - base == 4, "R6 user word", errs, 0);
  endtask

  task automatic t_zero;
    int base;
    cfg(2'd1, 0, 0, 0, 0, 0, 0);
    run(base, 0, 0, '0, '0);
    idle(3);
    check(done == 1 && busy == 0, "R7 zero-length done", done, 1);
    check(log_n == base, "R7 zero-length issue", log_n - base, 0);
  endtask

  task automatic t_reject;
    send(3'd5);
    idle(2);
    check(busy == 0, "R2 reserved idle", busy, 0);
    cfg(2'd1, 1, 0, 0, 0, 0, 5);
    @(negedge clk); ac_en = 1'b1; dx_en = 1'b1;
    send(3'd1);
    idle(3);
    check(busy == 0, "R3 both enables rejected", busy, 0);
    @(negedge clk); ac_en = 1'b0; dx_en = 1'b1;
  endtask

  task automatic t_failcount;
    int base;
    cfg(2'd1, 0, 0, 0, 0, 0, 10);
    run(base, 2, 6, 16'h0001, '0);
    wait_done("R8 done");
    check(fail_cnt == 4, "R8 mismatch count", fail_cnt, 4);
    check(fail == 1 && word_cnt == 10, "R8 fail set", fail, 1);
    cfg(2'd1, 0, 0, 0, 0, 0, 3);
    run(base, 0, 0, '0, '0);
    wait_done("R8 second run");
    check(fail == 1 && fail_cnt == 0, "R8 sticky across start", {fail, fail_cnt}, 9'h100);
    send(3'd3);
    check(fail == 0 && done == 0 && fail_cnt == 0, "R14 clear", {fail, done}, 0);
  endtask

  task automatic t_nth;
    int base, n0;
    cfg(2'd1, 0, 1, 8'd2, 0, 0, 60);
    run(base, 0, 1000, 16'h0001, '0);
    wait_done("R9 done");
    check(fail_cnt == 3, "R9 nth count", fail_cnt, 3);
    check(word_cnt < 60, "R9 early end", word_cnt, 60);
    n0 = log_n;
    idle(20);
    check(log_n == n0, "R9 issue stopped", log_n - n0, 0);
    send(3'd3);
  endtask

  task automatic t_inf;
    int base, n0;
    logic [CW-1:0] w0;
    cfg(2'd2, 1, 0, 0, 0, 0, 1);
    run(base, 0, 0, '0, '0);
    idle(50);
    check(busy == 1 && word_cnt > 40, "R10 unbounded running", word_cnt, 41);
    send(3'd6);
    check(busy == 1, "R2 reserved during run", busy, 1);
    w0 = word_cnt;
    send(3'd1);
    check(busy == 1 && word_cnt > w0, "R2 start while busy ignored", word_cnt, w0 + 1);
    send(3'd2);
    check(busy == 0 && done == 1, "R11 halt", {busy, done}, 1);
    n0 = log_n;
    idle(10);
    check(log_n == n0 && done == 1, "R11 no issue after halt", log_n - n0, 0);
    cfg(2'd2, 1, 0, 0, 0, 0, 1);
    run(base, 7, 8, 16'h8000, '0);
    wait_done("R10 fail end");
    check(fail_cnt == 1 && busy == 0, "R10 first failure ends", fail_cnt, 1);
    send(3'd3);
  endtask

  task automatic t_mask;
    int base, errs;
    cfg(2'd1, 0, 0, 0, 0, 1, 4);
    run(base, 1, 2, '0, 2'b01);
    wait_done("R12 loopback done");
    errs = 0;
    for (int k = 0; k < 4; k++) if (log_m[base+k] !== log_d[base+k][MW-1:0]) errs++;
    check(errs == 0, "R12 mask lanes driven", errs, 0);
    check(fail_cnt == 1, "R12 mask compared", fail_cnt, 1);
    cfg(2'd1, 0, 0, 0, 1, 1, 4);
    run(base, 0, 4, '0, 2'b11);
    wait_done("R12 dram done");
    errs = 0;
    for (int k = 0; k < 4; k++) if (log_m[base+k] !== '0) errs++;
    check(errs == 0, "R12 mask zero in dram mode", errs, 0);
    check(fail_cnt == 0, "R12 mask ignored in dram mode", fail_cnt, 0);
    send(3'd3);
  endtask

  task automatic t_sat;
    int base;
    cfg(2'd0, 0, 0, 0, 0, 0, 300);
    run(base, 0, 1000, 16'h0100, '0);
    wait_done("R13 done");
    check(fail_cnt == 8'hFF, "R13 saturation", fail_cnt, 255);
    check(word_cnt == 300, "R13 full length", word_cnt, 300);
    send(3'd3);
  endtask

  task automatic t_clr;
    int base, n0;
    cfg(2'd1, 0, 0, 0, 0, 0, 200);
    run(base, 0, 5, 16'h0001, '0);
    idle(15);
    check(fail == 1 && busy == 1, "R14 precondition", {fail, busy}, 3);
    send(3'd3);
    check(busy == 0 && done == 0 && fail == 0, "R14 abort flags", {busy, done, fail}, 0);
    check(fail_cnt == 0 && word_cnt == 0, "R14 abort counts", word_cnt, 0);
    n0 = log_n;
    idle(10);
    check(log_n == n0, "R14 no issue after clear", log_n - n0, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset();
    t_walk(1'b1);
    t_walk(1'b0);
    t_lfsr();
    t_user();
    t_zero();
    t_reject();
    t_failcount();
    t_nth();
    t_inf();
    t_mask();
    t_sat();
    t_clr();
    idle(5);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule